// File: doc/BRIEF.md
# Streaming Ready-Latency Protocol Monitor

This block watches a point-to-point streaming link without driving it. The link carries a data word, a channel tag and an error field from a source to a sink. It is qualified by a valid signal from the source and a ready signal from the sink. The monitor knows the link's ready latency through a parameter. From the ready history it works out which cycles the sink has opened for transfer. It reports sources that break the rules and counts the beats that complete.

Back-pressure rules it enforces:
- **Latency L ≥ 1.** The sink signals ready early. A cycle is open for transfer only when ready was high exactly L clock cycles before it. Valid in any other cycle is illegal. Valid in an open cycle is a completed beat.
- **Latency 0.** The handshake happens within the same cycle. A source may raise valid before ready. The beat moves only in a cycle where both valid and ready are high. Until that happens, the source must keep valid high and must keep data, channel and error unchanged.
- **Any latency.** Ready without valid moves nothing.

The monitor keeps one sticky flag per kind of violation. It also gives a one-cycle violation pulse and a saturating transfer count. All outputs are registered, so the effect of the inputs sampled at a rising edge shows after that edge.

Top module: `stream_rl_monitor`

## Requirements
- R1: While reset is applied at a rising edge, the transfer count, the violation pulse and both sticky flags are zero after that edge.
- R2: With LAT ≥ 1, a cycle is a ready cycle exactly when ready was high at the rising edge LAT cycles earlier.
- R3: With LAT ≥ 1, valid high in a cycle that is not a ready cycle sets sticky_bad_valid and raises viol_pulse after that cycle's edge.
- R4: With LAT ≥ 1, valid high in a ready cycle adds one to xfer_count after that cycle's edge.
- R5: With LAT = 0, a beat is counted only in a cycle where valid and ready are both high. Valid without ready is not an invalid-valid violation, so sticky_bad_valid stays 0.
- R6: A cycle with ready high and valid low counts no transfer and flags nothing.
- R7: With LAT = 0, if a stalled beat (valid high, ready low) is followed by a cycle with valid high but different data, channel or error, sticky_hold_err is set and viol_pulse is raised.
- R8: With LAT = 0, if a stalled beat is followed by a cycle with valid low, sticky_hold_err is set and viol_pulse is raised.
- R9: For the first LAT rising edges after reset is released, the interface is ignored: no count and no flag. Ready is still recorded in the history.
- R10: xfer_count saturates at 2^CNT_W − 1 and holds there.
- R11: Both sticky flags, once set, stay set until reset.
- R12: viol_pulse is high after an edge only if a violation was detected at that edge. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | Source valid of the monitored link |
| st_ready | input | 1 | Sink ready of the monitored link |
| st_data | input | DATA_W | Data word of the link |
| st_channel | input | CHAN_W | Channel tag of the link |
| st_error | input | ERR_W | Error field of the link |
| viol_pulse | output | 1 | One-cycle pulse for any violation |
| sticky_bad_valid | output | 1 | Valid seen outside a ready cycle (LAT ≥ 1) |
| sticky_hold_err | output | 1 | Stalled beat altered or withdrawn (LAT = 0) |
| xfer_count | output | CNT_W | Saturating count of completed beats |

## Verification
The bound checker tests these on every cycle:
- the reset state;
- that sticky flags never fall;
- that the count moves by at most one per cycle and sticks at its maximum;
- that a new flag always comes with a pulse;
- the silent warm-up window after reset.

Only the bench's scenarios can show whether the monitor picks the right cycles. This covers:
- ready cycles from a delayed ready history;
- which stalled-beat changes count as violations;
- how many beats a given ready/valid pattern completes.

The bench checks these with exhaustive sweeps of short ready, valid and data-change patterns on a latency-2 instance and a latency-0 instance.

// File: rtl/stream_mon_pkg.sv
package stream_mon_pkg;

  typedef struct packed {
    logic bad_valid;
    logic hold_break;
  } viol_t;

  function automatic logic any_viol(input viol_t v);
    return v.bad_valid | v.hold_break;
  endfunction

endpackage

// File: rtl/rdy_history.sv
module rdy_history #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ready,
  output logic ready_cycle
);

  generate
    if (LAT == 0) begin : g_direct
      assign ready_cycle = ready;
    end else begin : g_chain
      logic [LAT-1:0] hist_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          hist_q <= '0;
        end else begin
          hist_q[0] <= ready;
          for (int i = 1; i < LAT; i++) begin
            hist_q[i] <= hist_q[i-1];
          end
        end
      end
      assign ready_cycle = hist_q[LAT-1];
    end
  endgenerate

endmodule

// File: rtl/hold_tracker.sv
module hold_tracker #(
  parameter int BEAT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              valid,
  input  logic              ready,
  input  logic [BEAT_W-1:0] beat,
  output logic              hold_break
);

  logic              pend_q;
  logic [BEAT_W-1:0] saved_q;

  // A pending stalled beat must reappear unchanged with valid still high.
  assign hold_break = enable && pend_q && (!valid || (beat != saved_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      saved_q <= '0;
    end else begin
      pend_q <= enable && valid && !ready;
      if (valid && !ready) begin
        saved_q <= beat;
      end
    end
  end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q != TOP)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/stream_rl_monitor.sv
module stream_rl_monitor
  import stream_mon_pkg::*;
#(
  parameter int LAT    = 2,
  parameter int DATA_W = 32,
  parameter int CHAN_W = 4,
  parameter int ERR_W  = 2,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic              st_ready,
  input  logic [DATA_W-1:0] st_data,
  input  logic [CHAN_W-1:0] st_channel,
  input  logic [ERR_W-1:0]  st_error,
  output logic              viol_pulse,
  output logic              sticky_bad_valid,
  output logic              sticky_hold_err,
  output logic [CNT_W-1:0]  xfer_count
);

  localparam int BEAT_W = DATA_W + CHAN_W + ERR_W;
  localparam int WU_W   = (LAT > 0) ? $clog2(LAT + 1) : 1;

  logic [WU_W-1:0]   wu_q;
  logic              armed;
  logic              ready_cycle;
  logic              xfer_now;
  logic              hold_break;
  logic [BEAT_W-1:0] beat;
  viol_t             viol_now;

  // Warm-up: let the ready history fill before judging the link.
  assign armed = (int'(wu_q) == LAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      wu_q <= '0;
    end else if (!armed) begin
      wu_q <= wu_q + 1'b1;
    end
  end

  rdy_history #(.LAT(LAT)) hist_i (
    .clk         (clk),
    .rst         (rst),
    .ready       (st_ready),
    .ready_cycle (ready_cycle)
  );

  assign beat = {st_error, st_channel, st_data};

  hold_tracker #(.BEAT_W(BEAT_W)) hold_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (armed && (LAT == 0)),
    .valid      (st_valid),
    .ready      (st_ready),
    .beat       (beat),
    .hold_break (hold_break)
  );

  assign xfer_now           = armed && st_valid && ready_cycle;
  assign viol_now.bad_valid = armed && (LAT != 0) && st_valid && !ready_cycle;
  assign viol_now.hold_break = hold_break;

  sat_counter #(.W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst   (rst),
    .inc   (xfer_now),
    .count (xfer_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_pulse       <= 1'b0;
      sticky_bad_valid <= 1'b0;
      sticky_hold_err  <= 1'b0;
    end else begin
      viol_pulse       <= any_viol(viol_now);
      sticky_bad_valid <= sticky_bad_valid | viol_now.bad_valid;
      sticky_hold_err  <= sticky_hold_err | viol_now.hold_break;
    end
  end

endmodule

// File: rtl/stream_rl_monitor_chk.sv
module stream_rl_monitor_chk #(
  parameter int LAT   = 2,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             st_valid,
  input logic             viol_pulse,
  input logic             sticky_bad_valid,
  input logic             sticky_hold_err,
  input logic [CNT_W-1:0] xfer_count
);

  int since_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= 0;
    end else if (since_q < LAT) begin
      since_q <= since_q + 1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (xfer_count == '0 && !viol_pulse && !sticky_bad_valid && !sticky_hold_err));

  p_sticky_bad_r11: assert property (@(posedge clk) disable iff (rst)
    sticky_bad_valid |=> sticky_bad_valid);

  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (rst)
    sticky_hold_err |=> sticky_hold_err);

  p_flag_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    ($rose(sticky_bad_valid) || $rose(sticky_hold_err)) |-> viol_pulse);

  p_bad_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sticky_bad_valid) |-> $past(st_valid));

  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (xfer_count == $past(xfer_count) || xfer_count == $past(xfer_count) + 1'b1));

  p_saturate_r10: assert property (@(posedge clk) disable iff (rst)
    (&xfer_count) |=> (&xfer_count));

  p_zero_lat_r5: assert property (@(posedge clk) disable iff (rst)
    (LAT == 0) |-> !sticky_bad_valid);

  p_warmup_r9: assert property (@(posedge clk) disable iff (rst)
    (since_q < LAT) |=> (xfer_count == '0 && !viol_pulse));

endmodule

bind stream_rl_monitor stream_rl_monitor_chk #(.LAT(LAT), .CNT_W(CNT_W)) chk_i (
  .clk              (clk),
  .rst              (rst),
  .st_valid         (st_valid),
  .viol_pulse       (viol_pulse),
  .sticky_bad_valid (sticky_bad_valid),
  .sticky_hold_err  (sticky_hold_err),
  .xfer_count       (xfer_count)
);

// File: tb/stream_rl_monitor_tb_top.sv
module stream_rl_monitor_tb_top;

  localparam int DW = 8;
  localparam int CW = 2;
  localparam int EW = 2;
  localparam int NW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // latency-2 instance
  logic          rst_a, v_a, r_a;
  logic [DW-1:0] d_a;
  logic          pulse_a, badv_a, hold_a;
  logic [NW-1:0] cnt_a;

  // latency-0 instance
  logic          rst_z, v_z, r_z;
  logic [DW-1:0] d_z;
  logic [CW-1:0] c_z;
  logic [EW-1:0] e_z;
  logic          pulse_z, badv_z, hold_z;
  logic [NW-1:0] cnt_z;

  stream_rl_monitor #(.LAT(2), .DATA_W(DW), .CHAN_W(CW), .ERR_W(EW), .CNT_W(NW)) dut_i (
    .clk(clk), .rst(rst_a), .st_valid(v_a), .st_ready(r_a), .st_data(d_a),
    .st_channel(2'd1), .st_error(2'd0), .viol_pulse(pulse_a),
    .sticky_bad_valid(badv_a), .sticky_hold_err(hold_a), .xfer_count(cnt_a));

  stream_rl_monitor #(.LAT(0), .DATA_W(DW), .CHAN_W(CW), .ERR_W(EW), .CNT_W(NW)) dut_z_i (
    .clk(clk), .rst(rst_z), .st_valid(v_z), .st_ready(r_z), .st_data(d_z),
    .st_channel(c_z), .st_error(e_z), .viol_pulse(pulse_z),
    .sticky_bad_valid(badv_z), .sticky_hold_err(hold_z), .xfer_count(cnt_z));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_all();
    @(negedge clk);
    rst_a = 1; rst_z = 1;
    v_a = 0; r_a = 0; d_a = 0;
    v_z = 0; r_z = 0; d_z = 8'h5A; c_z = 0; e_z = 0;
    @(negedge clk);
    rst_a = 0; rst_z = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    reset_all();
    // R1 reset state
    chk("R1 count_a", int'(cnt_a), 0);
    chk("R1 flags_a", int'({pulse_a, badv_a, hold_a}), 0);
    chk("R1 count_z", int'(cnt_z), 0);
    chk("R1 flags_z", int'({pulse_z, badv_z, hold_z}), 0);

    // Latency-2 sweep: R2 R3 R4 R6 R9 R12
    for (int p = 0; p < 4096; p++) begin
      logic [5:0] rb;
      logic [5:0] vb;
      int ec;
      int eb;
      rb = p[5:0];
      vb = p[11:6];
      ec = 0; eb = 0;
      reset_all();
      chk("R1 sweep reset count", int'(cnt_a), 0);
      for (int t = 0; t < 6; t++) begin
        int ep;
        v_a = vb[t]; r_a = rb[t]; d_a = 8'(p + t);
        @(negedge clk);
        // R9: edges 0 and 1 are ignored; R2: ready cycle at t is rb[t-2]
        ep = (t >= 2 && vb[t] && !rb[t-2]) ? 1 : 0;
        if (t >= 2 && vb[t] && rb[t-2]) ec++;
        if (ep) eb = 1;
        chk("R12 R3 pulse lat2", int'(pulse_a), ep);
      end
      v_a = 0; r_a = 0;
      chk("R4 R2 R6 count lat2", int'(cnt_a), ec);
      chk("R3 R11 sticky lat2", int'(badv_a), eb);
      chk("R7 hold flag off lat2", int'(hold_a), 0);
    end

    // Latency-0 sweep: R5 R6 R7 R8 R12
    for (int p = 0; p < 4096; p++) begin
      logic [3:0] vb;
      logic [3:0] rb;
      logic [3:0] db;
      logic [7:0] cur;
      logic [7:0] saved;
      bit pend;
      int ec;
      int eh;
      vb = p[3:0]; rb = p[7:4]; db = p[11:8];
      cur = 8'h5A; saved = 0; pend = 0; ec = 0; eh = 0;
      reset_all();
      for (int t = 0; t < 4; t++) begin
        int ep;
        if (db[t]) cur = cur + 8'd1;
        v_z = vb[t]; r_z = rb[t]; d_z = cur;
        @(negedge clk);
        ep = (pend && (!vb[t] || cur != saved)) ? 1 : 0;
        if (ep) eh = 1;
        if (vb[t] && rb[t]) ec++;
        pend = vb[t] && !rb[t];
        if (pend) saved = cur;
        chk("R7 R8 R12 pulse lat0", int'(pulse_z), ep);
      end
      v_z = 0; r_z = 0;
      chk("R5 R6 count lat0", int'(cnt_z), ec);
      chk("R7 R8 sticky hold lat0", int'(hold_z), eh);
      chk("R5 no bad-valid lat0", int'(badv_z), 0);
    end

    // R7: channel change while stalled
    reset_all();
    v_z = 1; r_z = 0; c_z = 2'd1;
    @(negedge clk);
    c_z = 2'd2;
    @(negedge clk);
    chk("R7 channel change pulse", int'(pulse_z), 1);
    chk("R7 channel change sticky", int'(hold_z), 1);

    // R7: error field change while stalled
    reset_all();
    v_z = 1; r_z = 0; e_z = 2'd0;
    @(negedge clk);
    e_z = 2'd3;
    @(negedge clk);
    chk("R7 error change sticky", int'(hold_z), 1);
    // R11: sticky remains through clean cycles
    v_z = 0; r_z = 1;
    repeat (5) @(negedge clk);
    chk("R11 sticky holds", int'(hold_z), 1);
    chk("R12 pulse quiet", int'(pulse_z), 0);

    // R10: saturation
    reset_all();
    v_z = 1; r_z = 1;
    repeat (20) begin
      d_z = d_z + 8'd1;
      @(negedge clk);
    end
    chk("R10 saturated count", int'(cnt_z), 15);
    v_z = 0;

    // R3 R11 on latency 2: sticky bad-valid holds
    reset_all();
    r_a = 0; v_a = 0;
    repeat (2) @(negedge clk);
    v_a = 1;
    @(negedge clk);
    v_a = 0; r_a = 1;
    repeat (4) @(negedge clk);
    chk("R11 sticky bad-valid holds", int'(badv_a), 1);
    r_a = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule